// File: doc/BRIEF.md
# Infrared Frame Transmit End Controller

This block decides where an outgoing infrared frame stops and what the transmitter does afterwards. It follows the bytes that software pushes into the transmit FIFO and the bytes that the serializer actually shifts out. There are two ways a frame can end. In the first, software arms an end-of-transmission flag before it writes the last byte, and that byte is tagged as the final one. In the second, a frame-length counter is loaded at the start of each frame and reaches zero.

When the final byte leaves, the block sends a one-cycle request to the CRC/serializer stage. In the high-rate modes this request asks for a CRC followed by the end-of-frame sequence. In consumer-IR mode it asks for a graceful stop. A counter-ended frame can optionally halt the transmitter until software clears the halt. In consumer-IR mode, a stream that runs dry without the flag raises an underrun, and the transmitter stays blocked until software clears it.

Top module: `irtx_frame_end`

## Requirements
- R1: After reset, `eot_armed`, `eof_req`, `stop_req`, `halted` and `underrun` are 0, and `tx_en` is 1.
- R2: An `eot_set` pulse makes `eot_armed` 1 from the next cycle. A `fifo_wr` pulse without `eot_set` clears it, and the byte written in that cycle is tagged as the final byte of the frame.
- R3: In high-rate mode (`mode_cir`=0), the `byte_sent` of the tagged byte makes `eof_req` 1 for exactly the following cycle. Earlier bytes produce no `eof_req`.
- R4: With `len_mode`=1 and `frame_len`=N, the N-th `byte_sent` of a frame ends the frame and produces the same one-cycle request.
- R5: When the tagged byte is also the byte that brings the counter to zero, only one end-of-frame request is produced.
- R6: With `halt_en`=1, a counter-ended frame in high-rate mode sets `halted` and drops `tx_en`. A flag-ended frame does not set `halted`.
- R7: `halted` stays set until a `halt_clr` pulse, after which `halted` is 0 and `tx_en` is 1.
- R8: In consumer-IR mode, a `byte_sent` with `fifo_empty`=1 that does not end the frame sets `underrun` and drops `tx_en`. Both hold until a `urun_clr` pulse.
- R9: In consumer-IR mode, the tagged byte's `byte_sent` pulses `stop_req` for one cycle. It raises no `underrun` even if the FIFO is empty, and it produces no `eof_req`.
- R10: The frame-length counter reloads from `frame_len` for each new frame, so back-to-back frames each end after N bytes.
- R11: With `len_mode`=0, the counter never ends a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cir | input | 1 | 1 = consumer-IR mode, 0 = high-rate mode |
| len_mode | input | 1 | 1 = frame-length counter may end frames |
| halt_en | input | 1 | Halt after a counter-ended frame |
| frame_len | input | LEN_W | Programmed frame length in bytes |
| fifo_wr | input | 1 | Byte written into the transmit FIFO |
| fifo_empty | input | 1 | Transmit FIFO holds no byte |
| byte_sent | input | 1 | Serializer finished one byte |
| eot_set | input | 1 | Software arms the end-of-transmission flag |
| halt_clr | input | 1 | Write-one-to-clear of the halted status |
| urun_clr | input | 1 | Software clear of the underrun status |
| eot_armed | output | 1 | End-of-transmission flag state |
| eof_req | output | 1 | One-cycle CRC plus end-of-frame request |
| stop_req | output | 1 | One-cycle graceful-stop request (consumer-IR) |
| halted | output | 1 | Transmitter halted after a counter end |
| underrun | output | 1 | Consumer-IR underrun status |
| tx_en | output | 1 | Transmission allowed |

## Verification
The bench builds the block with `LEN_W`=12 and `OCC_W`=4. This keeps the full 12-bit counter width while the FIFO occupancy tracker covers up to 15 pending bytes. Frame lengths of 1 to 3 bytes are used so that a counter end, a reload, and a coincidence with a tagged byte each fall within a few sends. A length of 2 with `len_mode` cleared confirms that the counter is ignored.

// File: rtl/irtx_frame_end.sv
module irtx_frame_end #(
  parameter int LEN_W = 12,
  parameter int OCC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_cir,
  input  logic             len_mode,
  input  logic             halt_en,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             fifo_wr,
  input  logic             fifo_empty,
  input  logic             byte_sent,
  input  logic             eot_set,
  input  logic             halt_clr,
  input  logic             urun_clr,
  output logic             eot_armed,
  output logic             eof_req,
  output logic             stop_req,
  output logic             halted,
  output logic             underrun,
  output logic             tx_en
);

  logic [OCC_W-1:0] occ, tag_pos;
  logic [LEN_W-1:0] cnt;
  logic             in_frame;

  wire             tag_wr   = fifo_wr & eot_armed;
  wire             tag_hit  = byte_sent && (tag_pos == OCC_W'(1));
  wire [LEN_W-1:0] cur      = in_frame ? cnt : frame_len;
  wire             cnt_hit  = byte_sent && len_mode && (cur == LEN_W'(1));
  wire             end_hit  = tag_hit | cnt_hit;
  wire             urun_hit = mode_cir & byte_sent & fifo_empty & ~end_hit;

  assign tx_en = ~halted & ~underrun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eot_armed <= 1'b0;
      occ       <= '0;
      tag_pos   <= '0;
      cnt       <= '0;
      in_frame  <= 1'b0;
      eof_req   <= 1'b0;
      stop_req  <= 1'b0;
      halted    <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      eot_armed <= eot_set | (eot_armed & ~fifo_wr);
      occ       <= occ + OCC_W'(fifo_wr) - OCC_W'(byte_sent);
      if (tag_wr)
        tag_pos <= occ - OCC_W'(byte_sent) + OCC_W'(1);
      else if (byte_sent && tag_pos != '0)
        tag_pos <= tag_pos - OCC_W'(1);
      if (byte_sent) begin
        if (end_hit || urun_hit) begin
          in_frame <= 1'b0;
        end else begin
          in_frame <= 1'b1;
          cnt      <= cur - LEN_W'(1);
        end
      end
      eof_req  <= end_hit & ~mode_cir;
      stop_req <= end_hit & mode_cir;
      halted   <= (halt_en & cnt_hit & ~mode_cir) | (halted & ~halt_clr);
      underrun <= urun_hit | (underrun & ~urun_clr);
    end
  end

  p_armed_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr && !eot_set |=> !eot_armed);
  p_eof_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eof_req |-> $past(byte_sent) && !$past(mode_cir));
  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !halt_clr |=> halted);
  p_urun_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !urun_clr |=> underrun);
  p_stop_no_urun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !$rose(underrun));
  p_req_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(eof_req && stop_req));

endmodule

// File: tb/irtx_frame_end_test.sv
module irtx_frame_end_test;
  localparam int LEN_W = 12;
  logic clk = 0, rst_n = 0;
  logic mode_cir = 0, len_mode = 0, halt_en = 0;
  logic [LEN_W-1:0] frame_len = '0;
  logic fifo_wr = 0, fifo_empty = 1, byte_sent = 0, eot_set = 0, halt_clr = 0, urun_clr = 0;
  logic eot_armed, eof_req, stop_req, halted, underrun, tx_en;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irtx_frame_end #(.LEN_W(LEN_W), .OCC_W(4)) uut (
    .clk, .rst_n, .mode_cir, .len_mode, .halt_en, .frame_len, .fifo_wr, .fifo_empty,
    .byte_sent, .eot_set, .halt_clr, .urun_clr, .eot_armed, .eof_req, .stop_req,
    .halted, .underrun, .tx_en);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset(logic cir, logic lm, logic he, int len);
    @(negedge clk);
    rst_n = 0; mode_cir = cir; len_mode = lm; halt_en = he; frame_len = LEN_W'(len);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(logic tag);
    if (tag) begin
      eot_set = 1; @(negedge clk); eot_set = 0;
    end
    fifo_wr = 1; @(negedge clk); fifo_wr = 0;
  endtask

  task automatic send(logic empty);
    byte_sent = 1; fifo_empty = empty; @(negedge clk); byte_sent = 0; fifo_empty = 1;
  endtask

  task automatic pulse_idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(0, 0, 0, 0);
    chk("R1 eot_armed", eot_armed, 0); chk("R1 eof_req", eof_req, 0);
    chk("R1 stop_req", stop_req, 0); chk("R1 halted", halted, 0);
    chk("R1 underrun", underrun, 0); chk("R1 tx_en", tx_en, 1);
  endtask

  task automatic t_flag_end();
    do_reset(0, 0, 0, 0);
    wr(0); wr(0);
    eot_set = 1; @(negedge clk); eot_set = 0;
    chk("R2 armed", eot_armed, 1);
    wr(0);
    chk("R2 cleared", eot_armed, 0);
    send(0); chk("R3 byte1", eof_req, 0);
    send(0); chk("R3 byte2", eof_req, 0);
    send(1); chk("R3 tagged", eof_req, 1);
    pulse_idle(); chk("R3 one cycle", eof_req, 0);
  endtask

  task automatic t_counter();
    do_reset(0, 1, 0, 3);
    for (int i = 0; i < 6; i++) wr(0);
    send(0); send(0); chk("R4 byte2", eof_req, 0);
    send(0); chk("R4 byte3", eof_req, 1);
    send(0); chk("R10 next byte1", eof_req, 0);
    send(0); chk("R10 next byte2", eof_req, 0);
    send(1); chk("R10 next byte3", eof_req, 1);
    chk("R6 no halt when disabled", halted, 0);
  endtask

  task automatic t_coincide();
    int n = 0;
    do_reset(0, 1, 0, 2);
    wr(0); wr(1);
    send(0); n += int'(eof_req);
    send(1); n += int'(eof_req);
    pulse_idle(); n += int'(eof_req);
    pulse_idle(); n += int'(eof_req);
    chk("R5 single request", n == 1, 1);
  endtask

  task automatic t_halt();
    do_reset(0, 1, 1, 2);
    wr(0); wr(0);
    send(0); chk("R6 not yet", halted, 0);
    send(1); chk("R6 halted", halted, 1); chk("R6 tx_en", tx_en, 0);
    pulse_idle(); pulse_idle(); chk("R7 holds", halted, 1);
    halt_clr = 1; @(negedge clk); halt_clr = 0;
    chk("R7 cleared", halted, 0); chk("R7 tx_en", tx_en, 1);
    do_reset(0, 1, 1, 10);
    wr(1); send(1);
    chk("R6 flag end eof", eof_req, 1); chk("R6 flag end no halt", halted, 0);
  endtask

  task automatic t_underrun();
    do_reset(1, 0, 0, 0);
    wr(0); wr(0);
    send(0); chk("R8 not yet", underrun, 0);
    send(1); chk("R8 underrun", underrun, 1); chk("R8 tx_en", tx_en, 0);
    chk("R8 no stop", stop_req, 0);
    pulse_idle(); chk("R8 holds", underrun, 1);
    urun_clr = 1; @(negedge clk); urun_clr = 0;
    chk("R8 cleared", underrun, 0); chk("R8 tx_en back", tx_en, 1);
  endtask

  task automatic t_graceful();
    do_reset(1, 0, 0, 0);
    wr(0); wr(1);
    send(0); chk("R9 not yet", stop_req, 0);
    send(1); chk("R9 stop_req", stop_req, 1);
    chk("R9 no underrun", underrun, 0); chk("R9 no eof", eof_req, 0);
    pulse_idle(); chk("R9 one cycle", stop_req, 0);
  endtask

  task automatic t_no_len();
    int n = 0;
    do_reset(0, 0, 1, 2);
    wr(0); wr(0); wr(0);
    send(0); n += int'(eof_req);
    send(0); n += int'(eof_req);
    send(1); n += int'(eof_req);
    chk("R11 no counter end", n == 0, 1); chk("R11 no halt", halted, 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_flag_end(); t_counter(); t_coincide();
        t_halt(); t_underrun(); t_graceful(); t_no_len();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule